// File: doc/BRIEF.md
# SPI FIFO Event and Interrupt Unit

This unit sits between a host register port and the serial shifting engine of an SPI controller. It holds a 32-byte transmit queue and a 32-byte receive queue. The host fills the transmit queue and drains the receive queue through single data ports, one byte, two bytes or four bytes per access. The engine takes transmit bytes one at a time and hands back received bytes one at a time.

An event word gives the host live byte counts for both queues and a set of sticky event flags. A mask register with the same bit layout picks which flags drive the single interrupt line. Two threshold values, one per direction, set when the threshold flags fire. A flag is cleared by writing a one to its position. A flag whose condition still holds sets itself again on the next clock edge.

Host registers are selected by `host_addr`:

| `host_addr` | Register |
|---|---|
| 0 | control: transmit threshold in bits 13:8, receive threshold in bits 5:0 |
| 1 | event word |
| 2 | mask |
| 3 | transmit data port |
| 4 | receive data port |

Access width is set by `host_size`: 0 moves one byte, 1 moves two bytes, and 2 or 3 move four bytes. Register writes and queue pushes and pops take effect on the clock edge. Read data is combinational during the access cycle. Status flags follow the queue counts one cycle later.

Top module: `spi_fifo_evt`

## Requirements
- R1: Each direction holds 32 bytes. During reset and before the first edge after it, the event word reads 0x00200000: transmit free count 32 in bits 21:16, receive count 0 in bits 29:24, and all flags clear. Once out of reset it reads 0x00208900. The mask reads 0 and `irq` is low.
- R2: A write to the transmit port queues 1, 2 or 4 bytes, taken from wdata[7:0], wdata[15:0] or wdata[31:0] with the most significant byte sent first. The free count drops by the access width. The engine sees the bytes in queue order on `eng_tx_byte` while `eng_tx_valid` is high, and each `eng_tx_req` removes one byte.
- R3: A read of the receive port returns the oldest 1, 2 or 4 bytes right-justified, with the oldest byte most significant. The receive count drops by the access width.
- R4: A transmit write wider than the current free count is ignored: no byte is queued and the free count is unchanged.
- R5: A receive read wider than the current byte count returns 0 and leaves the queue and the count unchanged.
- R6: Flags sit in the event word at these positions: transmit-empty bit 15, receive-full bit 12, receive-not-empty bit 9 and transmit-not-full bit 8. Each is set one cycle after its condition holds and stays set until cleared. Bit 10 and all bits outside the flag and count fields read 0.
- R7: Control bits 13:8 hold the transmit threshold (reset value 4) and bits 5:0 hold the receive threshold (reset value 15). The receive-threshold flag (bit 13) sets when the receive count exceeds its threshold. The transmit-threshold flag (bit 11) sets when the free count is at least its threshold.
- R8: A one-cycle pulse on `eng_done` sets the transfer-done flag (bit 14).
- R9: Writing the event word clears each flag whose position in wdata[15:8] is one and leaves the other flags alone. A flag whose condition still holds is set again on the next edge.
- R10: The mask register uses the same positions as the event flags. `irq` is high exactly while some flag and its mask bit are both one.
- R11: An `eng_tx_req` on an empty transmit queue and an `eng_rx_valid` on a full receive queue are both ignored, and the counts stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register select (see the table above) |
| host_size | input | 2 | Access width: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, combinational, 0 when no read is selected |
| eng_tx_req | input | 1 | Engine takes the head transmit byte |
| eng_tx_valid | output | 1 | Transmit queue holds at least one byte |
| eng_tx_byte | output | 8 | Head transmit byte |
| eng_rx_valid | input | 1 | Engine delivers a received byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_done | input | 1 | Transfer-complete pulse |
| irq | output | 1 | Interrupt, high while a masked-in flag is set |

## Verification
The assertions assume the host makes at most one access per cycle and that `eng_done` is a single-cycle pulse. The ignore checks also assume that no engine transfer on the same queue lands in the same cycle as the access being tested. The stimulus follows these assumptions: every host access and every engine transfer is driven alone, and the next one starts only after an idle cycle. This also gives the flags time to follow the counts before the event word is read.

// File: rtl/spi_evt_pkg.sv
package spi_evt_pkg;

  // Host register select codes
  localparam logic [2:0] SEL_CTRL = 3'd0;
  localparam logic [2:0] SEL_EVT  = 3'd1;
  localparam logic [2:0] SEL_MASK = 3'd2;
  localparam logic [2:0] SEL_TXD  = 3'd3;
  localparam logic [2:0] SEL_RXD  = 3'd4;

  // Flag index inside the 8-bit flag byte (event word bits 15:8)
  localparam int FL_TXE = 7;
  localparam int FL_DON = 6;
  localparam int FL_RXT = 5;
  localparam int FL_RXF = 4;
  localparam int FL_TXT = 3;
  localparam int FL_RNE = 1;
  localparam int FL_TNF = 0;
  localparam logic [7:0] FL_VALID = 8'hFB;

  function automatic logic [2:0] width_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    width_bytes = 3'd1;
      2'd1:    width_bytes = 3'd2;
      default: width_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int DEPTH = 32,
  parameter int LANES = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int NW = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NW-1:0]     push_n,
  input  logic [8*LANES-1:0] push_data,
  input  logic [NW-1:0]     pop_n,
  output logic [8*LANES-1:0] peek,
  output logic [CW-1:0]     count
);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, wr_ptr_d;
  logic [AW-1:0] rd_ptr, rd_ptr_d;
  logic [CW-1:0] count_d;

  always_comb begin
    wr_ptr_d = wr_ptr + AW'(push_n);
    rd_ptr_d = rd_ptr + AW'(pop_n);
    count_d  = count + CW'(push_n) - CW'(pop_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      count  <= count_d;
    end
  end

  // Storage: one lane per byte of the widest access
  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (NW'(i) < push_n) mem[wr_ptr + AW'(i)] <= push_data[8*i +: 8];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_peek
    logic [AW-1:0] ra;
    assign ra = rd_ptr + AW'(g);
    assign peek[8*g +: 8] = mem[ra];
  end

endmodule

// File: rtl/spi_evt_flags.sv
module spi_evt_flags
  import spi_evt_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] tx_free,
  input  logic [CW-1:0] rx_cnt,
  input  logic [CW-1:0] tx_thr,
  input  logic [CW-1:0] rx_thr,
  input  logic          done_pulse,
  input  logic          clr_we,
  input  logic [7:0]    clr_bits,
  input  logic          mask_we,
  input  logic [7:0]    mask_wdata,
  output logic [7:0]    flags,
  output logic [7:0]    mask,
  output logic          irq
);

  logic [7:0] cond, flags_d, mask_d, clr_eff;

  always_comb begin
    cond         = '0;
    cond[FL_TXE] = (tx_free == CW'(DEPTH));
    cond[FL_DON] = done_pulse;
    cond[FL_RXT] = (rx_cnt > rx_thr);
    cond[FL_RXF] = (rx_cnt == CW'(DEPTH));
    cond[FL_TXT] = (tx_free >= tx_thr);
    cond[FL_RNE] = (rx_cnt != '0);
    cond[FL_TNF] = (tx_free != '0);
    clr_eff      = clr_we ? clr_bits : 8'h00;
    flags_d      = ((flags & ~clr_eff) | cond) & FL_VALID;
    mask_d       = mask_we ? (mask_wdata & FL_VALID) : mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      mask  <= '0;
    end else begin
      flags <= flags_d;
      mask  <= mask_d;
    end
  end

  assign irq = |(flags & mask);

endmodule

// File: rtl/spi_fifo_evt.sv
module spi_fifo_evt
  import spi_evt_pkg::*;
#(
  parameter int DEPTH      = 32,
  parameter int TX_THR_RST = 4,
  parameter int RX_THR_RST = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_sel,
  input  logic        host_wr,
  input  logic [2:0]  host_addr,
  input  logic [1:0]  host_size,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  input  logic        eng_tx_req,
  output logic        eng_tx_valid,
  output logic [7:0]  eng_tx_byte,
  input  logic        eng_rx_valid,
  input  logic [7:0]  eng_rx_byte,
  input  logic        eng_done,
  output logic        irq
);

  localparam int CW    = $clog2(DEPTH + 1);
  localparam int LANES = 4;
  localparam int NW    = $clog2(LANES + 1);

  // Reset: asserted asynchronously, released on the clock
  logic rst_s1, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_q  <= rst_s1;
    end
  end

  logic          is_wr, is_rd;
  logic [2:0]    nbytes;
  logic [CW-1:0] tx_cnt, tx_free, rx_cnt;
  logic [CW-1:0] tx_thr, rx_thr, tx_thr_d, rx_thr_d;
  logic          tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
  logic [NW-1:0] tx_push_n, tx_pop_n, rx_push_n, rx_pop_n;
  logic [31:0]   tx_push_data, tx_peek, rx_peek, rx_word, evt_word;
  logic [7:0]    evt_flags, evt_mask;
  logic          unused_tx_peek;

  assign is_wr   = host_sel & host_wr;
  assign is_rd   = host_sel & ~host_wr;
  assign nbytes  = width_bytes(host_size);
  assign tx_free = CW'(DEPTH) - tx_cnt;

  assign tx_push_ok = is_wr && (host_addr == SEL_TXD) && (CW'(nbytes) <= tx_free);
  assign tx_pop_ok  = eng_tx_req && (tx_cnt != '0);
  assign rx_push_ok = eng_rx_valid && (rx_cnt != CW'(DEPTH));
  assign rx_pop_ok  = is_rd && (host_addr == SEL_RXD) && (CW'(nbytes) <= rx_cnt);

  assign tx_push_n = tx_push_ok ? NW'(nbytes) : '0;
  assign tx_pop_n  = tx_pop_ok  ? NW'(1)      : '0;
  assign rx_push_n = rx_push_ok ? NW'(1)      : '0;
  assign rx_pop_n  = rx_pop_ok  ? NW'(nbytes) : '0;

  // Byte ordering: most significant byte of the access goes first
  always_comb begin
    tx_push_data = '0;
    rx_word      = '0;
    for (int k = 0; k < LANES; k++) begin
      if (k < int'(nbytes)) begin
        tx_push_data[8*k +: 8]                    = host_wdata[8*(int'(nbytes)-1-k) +: 8];
        rx_word[8*(int'(nbytes)-1-k) +: 8]        = rx_peek[8*k +: 8];
      end
    end
  end

  spi_byte_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_txq (
    .clk(clk), .rst_n(rst_q),
    .push_n(tx_push_n), .push_data(tx_push_data),
    .pop_n(tx_pop_n), .peek(tx_peek), .count(tx_cnt)
  );

  spi_byte_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_rxq (
    .clk(clk), .rst_n(rst_q),
    .push_n(rx_push_n), .push_data({24'h0, eng_rx_byte}),
    .pop_n(rx_pop_n), .peek(rx_peek), .count(rx_cnt)
  );

  assign eng_tx_valid   = (tx_cnt != '0);
  assign eng_tx_byte    = tx_peek[7:0];
  assign unused_tx_peek = ^tx_peek[31:8];

  // Threshold control register
  always_comb begin
    tx_thr_d = tx_thr;
    rx_thr_d = rx_thr;
    if (is_wr && (host_addr == SEL_CTRL)) begin
      tx_thr_d = host_wdata[8 +: CW];
      rx_thr_d = host_wdata[0 +: CW];
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      tx_thr <= CW'(TX_THR_RST);
      rx_thr <= CW'(RX_THR_RST);
    end else begin
      tx_thr <= tx_thr_d;
      rx_thr <= rx_thr_d;
    end
  end

  spi_evt_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst_n(rst_q),
    .tx_free(tx_free), .rx_cnt(rx_cnt),
    .tx_thr(tx_thr), .rx_thr(rx_thr),
    .done_pulse(eng_done),
    .clr_we(is_wr && (host_addr == SEL_EVT)), .clr_bits(host_wdata[15:8]),
    .mask_we(is_wr && (host_addr == SEL_MASK)), .mask_wdata(host_wdata[15:8]),
    .flags(evt_flags), .mask(evt_mask), .irq(irq)
  );

  always_comb begin
    evt_word            = '0;
    evt_word[24 +: CW]  = rx_cnt;
    evt_word[16 +: CW]  = tx_free;
    evt_word[15:8]      = evt_flags;
  end

  always_comb begin
    host_rdata = '0;
    if (is_rd) begin
      case (host_addr)
        SEL_CTRL: begin
          host_rdata[8 +: CW] = tx_thr;
          host_rdata[0 +: CW] = rx_thr;
        end
        SEL_EVT:  host_rdata = evt_word;
        SEL_MASK: host_rdata[15:8] = evt_mask;
        SEL_RXD:  host_rdata = rx_pop_ok ? rx_word : 32'h0;
        default:  host_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/spi_fifo_evt_chk.sv
module spi_fifo_evt_chk
  import spi_evt_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_sel,
  input logic          host_wr,
  input logic [2:0]    host_addr,
  input logic [1:0]    host_size,
  input logic          eng_tx_req,
  input logic          eng_rx_valid,
  input logic          eng_done,
  input logic          irq,
  input logic [CW-1:0] tx_free,
  input logic [CW-1:0] rx_cnt,
  input logic [7:0]    flags,
  input logic [7:0]    mask
);

  logic [CW-1:0] nb;
  assign nb = CW'(width_bytes(host_size));

  p_count_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_free <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

  p_tx_nofit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && host_wr && host_addr == SEL_TXD && nb > tx_free && !eng_tx_req)
    |=> (tx_free == $past(tx_free)));

  p_rx_short_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && !host_wr && host_addr == SEL_RXD && nb > rx_cnt && !eng_rx_valid)
    |=> (rx_cnt == $past(rx_cnt)));

  p_empty_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_free == CW'(DEPTH)) |=> flags[FL_TXE]);

  p_done_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> flags[FL_DON]);

  p_no_mask_no_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 8'h00) |-> !irq);

  p_rx_full_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == CW'(DEPTH) && eng_rx_valid && !(host_sel && !host_wr && host_addr == SEL_RXD))
    |=> (rx_cnt == CW'(DEPTH)));

  p_tx_empty_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_free == CW'(DEPTH) && eng_tx_req && !(host_sel && host_wr && host_addr == SEL_TXD))
    |=> (tx_free == CW'(DEPTH)));

endmodule

bind spi_fifo_evt spi_fifo_evt_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_q),
  .host_sel(host_sel), .host_wr(host_wr), .host_addr(host_addr), .host_size(host_size),
  .eng_tx_req(eng_tx_req), .eng_rx_valid(eng_rx_valid), .eng_done(eng_done),
  .irq(irq), .tx_free(tx_free), .rx_cnt(rx_cnt),
  .flags(evt_flags), .mask(evt_mask)
);

// File: tb/spi_fifo_evt_test.sv
module spi_fifo_evt_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_sel, host_wr;
  logic [2:0]  host_addr;
  logic [1:0]  host_size;
  logic [31:0] host_wdata, host_rdata;
  logic        eng_tx_req, eng_tx_valid, eng_rx_valid, eng_done, irq;
  logic [7:0]  eng_tx_byte, eng_rx_byte;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  spi_fifo_evt uut (
    .clk(clk), .rst_n(rst_n),
    .host_sel(host_sel), .host_wr(host_wr), .host_addr(host_addr),
    .host_size(host_size), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .eng_tx_req(eng_tx_req), .eng_tx_valid(eng_tx_valid), .eng_tx_byte(eng_tx_byte),
    .eng_rx_valid(eng_rx_valid), .eng_rx_byte(eng_rx_byte),
    .eng_done(eng_done), .irq(irq)
  );

  // Operation codes for the vector table
  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_RXP = 3'd2,
                         OP_TXP = 3'd3, OP_DONE = 3'd4, OP_IRQ = 3'd5;
  // Register codes: 0 control, 1 event, 2 mask, 3 tx port, 4 rx port
  // Entry layout: {op, addr, size, data, expected, req}
  localparam int NV = 50;
  localparam logic [79:0] VEC [NV] = '{
    {OP_RD,  3'd1, 2'd0, 32'h0, 32'h00208900, 8'd1},  // R1 idle event word
    {OP_RD,  3'd2, 2'd0, 32'h0, 32'h00000000, 8'd10}, // R10 mask reset
    {OP_RD,  3'd0, 2'd0, 32'h0, 32'h0000040F, 8'd7},  // R7 default thresholds
    {OP_WR,  3'd3, 2'd2, 32'hA1B2C3D4, 32'h0, 8'd2},  // R2
    {OP_WR,  3'd3, 2'd1, 32'h0000E5F6, 32'h0, 8'd2},
    {OP_WR,  3'd3, 2'd0, 32'h00000077, 32'h0, 8'd2},
    {OP_RD,  3'd1, 2'd0, 32'h0, 32'h00198900, 8'd2},  // R2 free 25
    {OP_TXP, 3'd0, 2'd0, 32'h0, 32'h000000A1, 8'd2},
    {OP_TXP, 3'd0, 2'd0, 32'h0, 32'h000000B2, 8'd2},
    {OP_TXP, 3'd0, 2'd0, 32'h0, 32'h000000C3, 8'd2},
    {OP_TXP, 3'd0, 2'd0, 32'h0, 32'h000000D4, 8'd2},
    {OP_TXP, 3'd0, 2'd0, 32'h0, 32'h000000E5, 8'd2},
    {OP_TXP, 3'd0, 2'd0, 32'h0, 32'h000000F6, 8'd2},
    {OP_TXP, 3'd0, 2'd0, 32'h0, 32'h00000077, 8'd2},
    {OP_WR,  3'd1, 2'd0, 32'h0000FF00, 32'h0, 8'd9},  // R9 clear all
    {OP_RD,  3'd1, 2'd0, 32'h0, 32'h00208900, 8'd9},  // R9 live ones re-set
    {OP_RXP, 3'd0, 2'd0, 32'h11, 32'h0, 8'd3},
    {OP_RXP, 3'd0, 2'd0, 32'h22, 32'h0, 8'd3},
    {OP_RXP, 3'd0, 2'd0, 32'h33, 32'h0, 8'd3},
    {OP_RXP, 3'd0, 2'd0, 32'h44, 32'h0, 8'd3},
    {OP_RXP, 3'd0, 2'd0, 32'h55, 32'h0, 8'd3},
    {OP_RD,  3'd1, 2'd0, 32'h0, 32'h05208B00, 8'd6},  // R6 not-empty flag
    {OP_RD,  3'd4, 2'd2, 32'h0, 32'h11223344, 8'd3},  // R3 word read
    {OP_RD,  3'd4, 2'd1, 32'h0, 32'h00000000, 8'd5},  // R5 short pop ignored
    {OP_RD,  3'd4, 2'd0, 32'h0, 32'h00000055, 8'd3},  // R3 byte read
    {OP_RD,  3'd1, 2'd0, 32'h0, 32'h00208B00, 8'd6},  // R6 sticky
    {OP_WR,  3'd1, 2'd0, 32'h00000200, 32'h0, 8'd9},
    {OP_RD,  3'd1, 2'd0, 32'h0, 32'h00208900, 8'd9},  // R9 single clear
    {OP_WR,  3'd0, 2'd0, 32'h00002102, 32'h0, 8'd7},
    {OP_RD,  3'd0, 2'd0, 32'h0, 32'h00002102, 8'd7},  // R7
    {OP_WR,  3'd1, 2'd0, 32'h00000800, 32'h0, 8'd7},
    {OP_RD,  3'd1, 2'd0, 32'h0, 32'h00208100, 8'd7},  // R7 32 < 33
    {OP_RXP, 3'd0, 2'd0, 32'hAA, 32'h0, 8'd7},
    {OP_RXP, 3'd0, 2'd0, 32'hBB, 32'h0, 8'd7},
    {OP_RXP, 3'd0, 2'd0, 32'hCC, 32'h0, 8'd7},
    {OP_RD,  3'd1, 2'd0, 32'h0, 32'h0320A300, 8'd7},  // R7 3 > 2
    {OP_WR,  3'd2, 2'd0, 32'h00002000, 32'h0, 8'd10},
    {OP_IRQ, 3'd0, 2'd0, 32'h0, 32'h00000001, 8'd10}, // R10
    {OP_RD,  3'd2, 2'd0, 32'h0, 32'h00002000, 8'd10},
    {OP_WR,  3'd1, 2'd0, 32'h00002000, 32'h0, 8'd9},
    {OP_IRQ, 3'd0, 2'd0, 32'h0, 32'h00000001, 8'd9},  // R9 condition holds
    {OP_WR,  3'd0, 2'd0, 32'h00000403, 32'h0, 8'd7},
    {OP_WR,  3'd1, 2'd0, 32'h00002000, 32'h0, 8'd9},
    {OP_IRQ, 3'd0, 2'd0, 32'h0, 32'h00000000, 8'd10}, // R10
    {OP_DONE,3'd0, 2'd0, 32'h0, 32'h0, 8'd8},
    {OP_RD,  3'd1, 2'd0, 32'h0, 32'h0320CB00, 8'd8},  // R8 done flag
    {OP_WR,  3'd2, 2'd0, 32'h00004000, 32'h0, 8'd10},
    {OP_IRQ, 3'd0, 2'd0, 32'h0, 32'h00000001, 8'd10},
    {OP_WR,  3'd1, 2'd0, 32'h00004000, 32'h0, 8'd9},
    {OP_IRQ, 3'd0, 2'd0, 32'h0, 32'h00000000, 8'd9}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    host_sel = 1'b0; host_wr = 1'b0; host_addr = '0; host_size = '0;
    host_wdata = '0; eng_tx_req = 1'b0; eng_rx_valid = 1'b0;
    eng_rx_byte = '0; eng_done = 1'b0;
  endtask

  // One operation: drive at a falling edge, sample 2 ns later, release at the
  // next falling edge; the following operation leaves one idle cycle.
  task automatic do_op(input logic [2:0] op, input logic [2:0] a, input logic [1:0] s,
                       input logic [31:0] d, output logic [31:0] got);
    @(negedge clk);
    case (op)
      OP_WR:  begin host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_size = s; host_wdata = d; end
      OP_RD:  begin host_sel = 1'b1; host_wr = 1'b0; host_addr = a; host_size = s; end
      OP_RXP: begin eng_rx_valid = 1'b1; eng_rx_byte = d[7:0]; end
      OP_TXP: eng_tx_req = 1'b1;
      OP_DONE: eng_done = 1'b1;
      default: ;
    endcase
    #2;
    case (op)
      OP_RD:  got = host_rdata;
      OP_TXP: got = {23'h0, eng_tx_valid, eng_tx_byte};
      OP_IRQ: got = {31'h0, irq};
      default: got = '0;
    endcase
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic rd_field(input logic [2:0] a, input logic [1:0] s, output logic [31:0] v);
    do_op(OP_RD, a, s, 32'h0, v);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h1, 32'h0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] got, exp;
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state seen while reset is held
    host_sel = 1'b1; host_addr = 3'd1; #1;
    check(host_rdata == 32'h00200000, "R1 event word in reset", host_rdata, 32'h00200000);
    check(irq == 1'b0, "R1 irq in reset", {31'h0, irq}, 32'h0);
    idle_inputs();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [79:0] v;
      v = VEC[i];
      do_op(v[79:77], v[76:74], v[73:72], v[71:40], got);
      case (v[79:77])
        OP_RD, OP_IRQ: check(got == v[39:8], $sformatf("R%0d vector %0d", v[7:0], i), got, v[39:8]);
        OP_TXP: check(got == {23'h0, 1'b1, v[15:8]}, $sformatf("R%0d vector %0d", v[7:0], i),
                      got, {23'h0, 1'b1, v[15:8]});
        default: ;
      endcase
    end

    // R1: reset mid-run returns to the idle state (RX holds 3 bytes here)
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd_field(3'd1, 2'd0, got);
    check(got == 32'h00208900, "R1 event word after reset", got, 32'h00208900);
    rd_field(3'd0, 2'd0, got);
    check(got == 32'h0000040F, "R1 thresholds after reset", got, 32'h0000040F);

    // R4: overflow attempts on the TX queue
    for (int k = 0; k < 7; k++) do_op(OP_WR, 3'd3, 2'd2, 32'h01020304 + k, got);
    do_op(OP_WR, 3'd3, 2'd1, 32'h00001234, got);
    do_op(OP_WR, 3'd3, 2'd2, 32'hDEADBEEF, got);   // 4 > 2 free, ignored
    rd_field(3'd1, 2'd0, got);
    check(got[21:16] == 6'd2, "R4 free after too-wide write", {26'h0, got[21:16]}, 32'd2);
    do_op(OP_WR, 3'd3, 2'd1, 32'h0000BEEF, got);
    do_op(OP_WR, 3'd3, 2'd0, 32'h00000099, got);   // queue full, ignored
    rd_field(3'd1, 2'd0, got);
    check(got[21:16] == 6'd0, "R4 free when full", {26'h0, got[21:16]}, 32'd0);
    do_op(OP_WR, 3'd1, 2'd0, 32'h00000100, got);   // clear TNF while full
    rd_field(3'd1, 2'd0, got);
    check(got[8] == 1'b0, "R9 not-full stays clear when full", {31'h0, got[8]}, 32'h0);
    for (int k = 0; k < 30; k++) do_op(OP_TXP, 3'd0, 2'd0, 32'h0, got);
    do_op(OP_TXP, 3'd0, 2'd0, 32'h0, got);
    check(got == 32'h000001BE, "R4 byte 31", got, 32'h000001BE);
    do_op(OP_TXP, 3'd0, 2'd0, 32'h0, got);
    check(got == 32'h000001EF, "R4 last byte, nothing extra queued", got, 32'h000001EF);
    // R11: pop on empty TX queue
    do_op(OP_TXP, 3'd0, 2'd0, 32'h0, got);
    check(got[8] == 1'b0, "R11 tx valid low when empty", {31'h0, got[8]}, 32'h0);
    rd_field(3'd1, 2'd0, got);
    check(got[21:16] == 6'd32, "R11 free stays 32", {26'h0, got[21:16]}, 32'd32);

    // R11 and R6: overfill RX queue, byte 32 is dropped
    for (int k = 0; k < 33; k++) do_op(OP_RXP, 3'd0, 2'd0, 32'(k), got);
    rd_field(3'd1, 2'd0, got);
    check(got[29:24] == 6'd32, "R11 rx count capped", {26'h0, got[29:24]}, 32'd32);
    check(got[12] == 1'b1, "R6 rx full flag", {31'h0, got[12]}, 32'h1);
    for (int k = 0; k < 8; k++) begin
      do_op(OP_RD, 3'd4, 2'd2, 32'h0, got);
      exp = {8'(4*k), 8'(4*k+1), 8'(4*k+2), 8'(4*k+3)};
      check(got == exp, "R3 drain word", got, exp);
    end
    rd_field(3'd1, 2'd0, got);
    check(got[29:24] == 6'd0, "R11 dropped byte absent", {26'h0, got[29:24]}, 32'd0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule